// File: doc/BRIEF.md
# Ping-Pong Parity Scrubber

The block sits between a streaming datapath and two parity-protected memory banks holding the same working set. Each streamed access carries an iteration index and an address. The parity of the iteration index picks the bank that is read. The word that comes back goes downstream as an operand. One cycle later the same word is written into the opposite bank, at the same address, with freshly generated parity. Every word is therefore rewritten once per pass, so scrubbing rides on normal traffic and no background sweep is needed.

Parity is even and computed per byte. A mismatch on any byte of a read word raises a per-read error strobe. It also sets a sticky error flag and advances a saturating error counter; the flag and the counter stay set until a clear pulse. An initialization mode loads the same word into both banks from the input stream before scrubbing starts. During initialization an injection mask can flip data bits after parity has been generated, which plants faults on purpose.

Top module: `pp_scrub`

## Requirements
- R1: A request with `init_i`=1 writes `wdata_i` into both banks at `addr_i`. The parity is generated from `wdata_i`, and the stored data bits are `wdata_i ^ inj_mask_i`. An init request produces no read: `rvalid_o` stays 0 in the following cycle.
- R2: A read request (`req_i`=1, `init_i`=0) with `iter_i[0]`=1 (odd) reads bank A. With `iter_i[0]`=0 (even) it reads bank B.
- R3: `rvalid_o` and `rdata_o` are valid in the cycle after the read request. `rdata_o` equals the stored data bits.
- R4: The cycle after a read, the word read is written into the other bank at the same address, with parity regenerated from the data read.
- R5: Parity bit k is even parity over data bits [8k+7:8k]. `par_err_o` is 1, together with `rvalid_o`, when any byte's stored parity mismatches its data. Two flips within one byte go undetected.
- R6: `err_o` goes to 1 the cycle after `par_err_o` and stays 1 until `clear_i`. If a new error and `clear_i` coincide, the error wins.
- R7: `err_cnt_o` increments once per parity error and saturates at 2^CNT_W-1. `clear_i` resets it to 0, or to 1 if an error coincides with the clear.
- R8: After reset, `rvalid_o`, `par_err_o`, `err_o` and `err_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| init_i | input | 1 | 1: load both banks, 0: scrubbing read |
| iter_i | input | ITER_W | Iteration index; bit 0 selects the bank |
| addr_i | input | $clog2(DEPTH) | Word address |
| wdata_i | input | DATA_W | Init data |
| inj_mask_i | input | DATA_W | Bit flips applied to init data after parity generation |
| clear_i | input | 1 | Clears the sticky flag and the counter |
| rdata_o | output | DATA_W | Word read, forwarded downstream |
| rvalid_o | output | 1 | Read data valid |
| par_err_o | output | 1 | Parity mismatch on the current read |
| err_o | output | 1 | Sticky error flag |
| err_cnt_o | output | CNT_W | Saturating error count |

## Verification
A wrong bank select or a missing write-back does not show at once. It shows on a later access to the same address: a planted fault is reported again where a clean word was due, or a clean word is reported where the fault should still be present. The directed sequences therefore read one corrupted address repeatedly, with chosen iteration parities, so each such state error reaches `par_err_o` within one or two accesses. Flag and counter faults show one cycle after the erroring read, at `err_o` and `err_cnt_o`.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/par_gen.sv
module par_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]                     data_i,
  output logic [DATA_W/scrub_pkg::BYTE_W-1:0]   par_o
);
  localparam int unsigned PW = DATA_W / scrub_pkg::BYTE_W;
  for (genvar k = 0; k < PW; k++) begin : g_byte
    assign par_o[k] = ^data_i[k*scrub_pkg::BYTE_W +: scrub_pkg::BYTE_W];
  end
endmodule

// File: rtl/scrub_bank.sv
module scrub_bank #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wword_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rword_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wword_i;
  end

  // registered read, old data on same-address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rword_o <= '0;
    else if (re_i) rword_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/err_trk.sv
module err_trk #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             clear_i,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
      cnt_o <= '0;
    end else if (clear_i) begin
      err_o <= err_i;
      cnt_o <= {{(CNT_W-1){1'b0}}, err_i};
    end else if (err_i) begin
      err_o <= 1'b1;
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_o);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> err_o);
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clear_i) |=> cnt_o == CNT_MAX);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !err_i) |=> (cnt_o == '0 && !err_o));
endmodule

// File: rtl/pp_scrub.sv
module pp_scrub #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ITER_W = 16,
  parameter int unsigned CNT_W  = 3,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = DATA_W / scrub_pkg::BYTE_W,
  localparam int unsigned WW    = DATA_W + PW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              init_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] inj_mask_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              par_err_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  import scrub_pkg::*;

  logic          rd_req;
  bank_e         rd_bank;
  bank_e         rsel_q;
  logic [AW-1:0] raddr_q;
  logic          rv_q;
  logic [PW-1:0] init_par, chk_par, stored_par;
  logic [WW-1:0] init_word, wb_word, rd_word;
  logic [WW-1:0] bank_q [2];

  assign rd_req  = req_i && !init_i;
  assign rd_bank = iter_i[0] ? BANK_A : BANK_B;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q    <= 1'b0;
      rsel_q  <= BANK_A;
      raddr_q <= '0;
    end else begin
      rv_q <= rd_req;
      if (rd_req) begin
        rsel_q  <= rd_bank;
        raddr_q <= addr_i;
      end
    end
  end

  par_gen #(.DATA_W(DATA_W)) u_init_par (.data_i(wdata_i), .par_o(init_par));
  assign init_word = {init_par, wdata_i ^ inj_mask_i};

  assign rd_word    = (rsel_q == BANK_A) ? bank_q[0] : bank_q[1];
  assign rdata_o    = rd_word[DATA_W-1:0];
  assign stored_par = rd_word[WW-1:DATA_W];
  par_gen #(.DATA_W(DATA_W)) u_chk_par (.data_i(rdata_o), .par_o(chk_par));
  assign wb_word    = {chk_par, rdata_o};
  assign rvalid_o   = rv_q;
  assign par_err_o  = rv_q && (chk_par != stored_par);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam bank_e ME = (b == 0) ? BANK_A : BANK_B;
    logic          wb_hit, we, re;
    logic [AW-1:0] waddr;
    logic [WW-1:0] wword;

    // write-back goes to the bank not read; it wins over an init write
    assign wb_hit = rv_q && (rsel_q != ME);
    assign we     = wb_hit || (req_i && init_i);
    assign waddr  = wb_hit ? raddr_q : addr_i;
    assign wword  = wb_hit ? wb_word : init_word;
    assign re     = rd_req && (rd_bank == ME);

    scrub_bank #(.WORD_W(WW), .DEPTH(DEPTH)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .waddr_i (waddr),
      .wword_i (wword),
      .re_i    (re),
      .raddr_i (addr_i),
      .rword_o (bank_q[b])
    );
  end

  err_trk #(.CNT_W(CNT_W)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (par_err_o),
    .clear_i (clear_i),
    .err_o   (err_o),
    .cnt_o   (err_cnt_o)
  );

  p_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  p_init_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || init_i) |=> !rvalid_o);
  p_err_needs_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> rvalid_o);
  p_wb_one_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $countones({g_bank[0].wb_hit, g_bank[1].wb_hit}) == 1);
endmodule

// File: tb/tb_pp_scrub.sv
module tb_pp_scrub;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, init = 1'b0, clr = 1'b0;
  logic [15:0]   iter = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, mask = '0;
  logic [DW-1:0] rdata;
  logic          rvalid, par_err, err;
  logic [CW-1:0] cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_scrub #(.DATA_W(DW), .DEPTH(64), .ITER_W(16), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .init_i(init), .iter_i(iter),
    .addr_i(addr), .wdata_i(wdata), .inj_mask_i(mask), .clear_i(clr),
    .rdata_o(rdata), .rvalid_o(rvalid), .par_err_o(par_err), .err_o(err),
    .err_cnt_o(cnt)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic mask_err(input logic [DW-1:0] m);
    logic e = 1'b0;
    for (int k = 0; k < DW/8; k++) e |= ^m[k*8 +: 8];
    return e;
  endfunction

  task automatic do_init(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] m);
    @(negedge clk);
    req = 1'b1; init = 1'b1; addr = a; wdata = d; mask = m;
    @(negedge clk);
    req = 1'b0; init = 1'b0; mask = '0;
    chk("R1 no valid after init", {31'b0, rvalid}, 0);
  endtask

  // read; checks data/valid/error one cycle later; optional clear in result cycle
  task automatic do_read(input string tag, input logic odd, input logic [AW-1:0] a,
                         input logic [DW-1:0] exp_d, input logic exp_e, input logic c);
    @(negedge clk);
    req = 1'b1; init = 1'b0; iter = {15'd7, odd}; addr = a;
    @(negedge clk);
    req = 1'b0; clr = c;
    chk({tag, " R3 valid"}, {31'b0, rvalid}, 1);
    chk({tag, " R3 data"}, rdata, exp_d);
    chk({tag, " R5 par_err"}, {31'b0, par_err}, {31'b0, exp_e});
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R6 err cleared", {31'b0, err}, 0);
    chk("R7 cnt cleared", {29'b0, cnt}, 0);
  endtask

  task automatic t_reset();
    chk("R8 rvalid", {31'b0, rvalid}, 0);
    chk("R8 par_err", {31'b0, par_err}, 0);
    chk("R8 err", {31'b0, err}, 0);
    chk("R8 cnt", {29'b0, cnt}, 0);
  endtask

  task automatic t_clean();
    do_init(6'd3, 32'hA5A5_1234, '0);
    do_read("clean odd R2", 1'b1, 6'd3, 32'hA5A5_1234, 1'b0, 1'b0);
    do_read("clean even R2", 1'b0, 6'd3, 32'hA5A5_1234, 1'b0, 1'b0);
    chk("R6 no err", {31'b0, err}, 0);
  endtask

  task automatic t_pingpong();
    logic [DW-1:0] d = 32'h0F0F_C3C3 ^ 32'h0000_0100;
    do_init(6'd5, 32'h0F0F_C3C3, 32'h0000_0100);
    do_read("pp odd A R2", 1'b1, 6'd5, d, 1'b1, 1'b0);
    chk("R6 err set", {31'b0, err}, 1);
    chk("R7 cnt 1", {29'b0, cnt}, 1);
    do_read("pp even B rewritten R4", 1'b0, 6'd5, d, 1'b0, 1'b0);
    do_read("pp odd A rewritten R4", 1'b1, 6'd5, d, 1'b0, 1'b0);
    chk("R6 err sticky", {31'b0, err}, 1);
    do_init(6'd6, 32'h1111_2222, 32'h0001_0000);
    do_read("pp even B R2", 1'b0, 6'd6, 32'h1110_2222, 1'b1, 1'b0);
    do_read("pp even B again R2", 1'b0, 6'd6, 32'h1110_2222, 1'b1, 1'b0);
    do_read("pp odd A clean R4", 1'b1, 6'd6, 32'h1110_2222, 1'b0, 1'b0);
    chk("R7 cnt 3", {29'b0, cnt}, 3);
    do_clear();
  endtask

  task automatic t_saturate();
    do_init(6'd7, 32'hDEAD_BEEF, 32'h0000_0001);
    for (int i = 0; i < 9; i++)
      do_read("sat even R7", 1'b0, 6'd7, 32'hDEAD_BEEE, 1'b1, 1'b0);
    chk("R7 saturated", {29'b0, cnt}, 7);
    do_read("clr+err R6", 1'b0, 6'd7, 32'hDEAD_BEEE, 1'b1, 1'b1);
    chk("R6 error wins over clear", {31'b0, err}, 1);
    chk("R7 cnt 1 after clear+err", {29'b0, cnt}, 1);
    do_clear();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] m;
    m = 32'h0000_0003;
    do_init(6'd8, 32'h5555_AAAA, m);
    do_read("same byte R5", 1'b1, 6'd8, 32'h5555_AAAA ^ m, mask_err(m), 1'b0);
    chk("R6 no err on double flip", {31'b0, err}, 0);
    m = 32'h0100_0001;
    do_init(6'd9, 32'h5555_AAAA, m);
    do_read("two bytes R5", 1'b1, 6'd9, 32'h5555_AAAA ^ m, mask_err(m), 1'b0);
    chk("R6 err after byte fault", {31'b0, err}, 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_pingpong();
    t_saturate();
    t_bytes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule